// File: doc/BRIEF.md
# Latency-Matrix Issue Interlock

This block is the issue stage of a single-issue, in-order pipeline that has an integer register file and a floating-point register file. Each cycle it may be offered one decoded instruction. The instruction carries a class, an optional destination register and up to two optional source registers. For every register, the block remembers how many cycles ago its most recent producer issued and what class that producer was. An offered instruction is held, with a stall strobe, until each of its true sources has cleared the gap that the producer/consumer pair demands. It is then issued.

The required gap is not one uniform result latency. It is a small matrix indexed by producer class, consumer class and, for stores, by whether the operand is the stored data or the address. A gap is the number of cycles between the producer's issue and the consumer's issue in which the producer's result is not yet usable. Independent instructions that issue inside that window count toward it. The block does not model branch delay slots itself. The instruction stream it receives already contains whatever fills the slot after a branch, and a NOP in that slot simply takes one issue cycle. A running counter adds up every cycle in which an instruction was offered, whether it issued or stalled. This lets the cost of a code schedule be read off directly.

Top module: `issue_interlock`

## Requirements
- R1: An FP ALU instruction (class code 1) that reads a register written by an FP ALU instruction issues no earlier than with 3 empty cycles after the producer's issue cycle.
- R2: A store (class code 2) whose stored-data operand (operand b) was written by an FP ALU instruction issues with at least 2 empty cycles after the producer.
- R3: An FP ALU instruction that reads a register written by a load (class code 0) issues with at least 1 empty cycle after the load.
- R4: A store whose stored-data operand was written by a load needs no empty cycle and issues in the cycle right after the load.
- R5: A branch (class code 4) testing operand a written by an integer ALU instruction (class code 3) issues with at least 1 empty cycle after the producer.
- R6: Gaps are measured in cycles since the producer issued. Independent instructions that issue in between shorten the stall, and a consumer is never stalled longer than its largest pending requirement.
- R7: Only true dependences stall. Writing a register that an earlier instruction read, writing a register that an earlier instruction wrote, and any producer/consumer pair not listed in R1 to R5 (for example a store address, operand a, from an integer result) cause no stall.
- R8: Integer register 0 (specifier 0) is never a dependence source. FP register 0 (specifier 32) is an ordinary register. Register specifiers are 6 bits, and bit 5 set selects the FP file.
- R9: While an instruction is offered and a hazard is pending, `stall` is high and `in_ready` is low. In the first cycle all hazards have cleared, `issue` and `in_ready` are high. `issue` and `stall` are never both high.
- R10: `cycle_cnt` is 0 after reset and increases by exactly one at each clock edge where `issue` or `stall` was high. It holds while nothing is offered.
- R11: Under the default gaps, the following streams cost the stated counts when offered back to back. A loop of load, FP add, store, pointer decrement, branch and NOP costs 10 cycles per pass, or 20 for two passes. The same loop with the store moved into the slot after the branch costs 7. The four-way unrolled loop, with loads grouped, then adds, then the decrement, then three stores, the branch and the last store in the slot, costs 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | Offered instruction has no pending hazard |
| in_cls | input | 3 | Class: 0 load, 1 FP ALU, 2 store, 3 integer ALU, 4 branch, 5 NOP |
| in_dst_en | input | 1 | Instruction writes a destination |
| in_dst | input | AW | Destination register specifier |
| in_a_en | input | 1 | Operand a is read |
| in_a | input | AW | Operand a specifier (store address, branch test) |
| in_b_en | input | 1 | Operand b is read |
| in_b | input | AW | Operand b specifier (store data for stores) |
| issue | output | 1 | Instruction issued this cycle |
| stall | output | 1 | Instruction offered but held this cycle |
| cycle_cnt | output | CW | Count of offered cycles |

## Verification
The bench builds the block with its default parameters: 6-bit specifiers, a 16-bit counter and gaps of 3, 2, 1, 0 and 1. With these defaults the whole latency matrix is reachable, and the loop totals of R11 can be compared against the figures in the requirement. A behavioural model tracks the issue cycle and the class of the last writer of each register. On every clock it predicts ready, stall and the counter. Short directed pairs then probe each matrix entry, the filler case, name-only reuse and integer register 0.

// File: rtl/issue_interlock.sv
module issue_interlock #(
  parameter int AW     = 6,
  parameter int CW     = 16,
  parameter int LAT_FF = 3,
  parameter int LAT_FS = 2,
  parameter int LAT_LF = 1,
  parameter int LAT_LS = 0,
  parameter int LAT_IB = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_cls,
  input  logic          in_dst_en,
  input  logic [AW-1:0] in_dst,
  input  logic          in_a_en,
  input  logic [AW-1:0] in_a,
  input  logic          in_b_en,
  input  logic [AW-1:0] in_b,
  output logic          issue,
  output logic          stall,
  output logic [CW-1:0] cycle_cnt
);
  localparam int NR   = 1 << AW;
  localparam int M1   = (LAT_FF > LAT_FS) ? LAT_FF : LAT_FS;
  localparam int M2   = (LAT_LF > LAT_LS) ? LAT_LF : LAT_LS;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int LMAX = (M3 > LAT_IB) ? M3 : LAT_IB;
  localparam int AGW  = $clog2(LMAX + 2);
  localparam logic [AGW-1:0] AMAX = {AGW{1'b1}};

  localparam logic [2:0] C_LD = 3'd0, C_FP = 3'd1, C_SD = 3'd2,
                         C_INT = 3'd3, C_BR = 3'd4, C_NOP = 3'd5;

  logic [AGW-1:0] age  [NR];
  logic [2:0]     pcls [NR];
  logic           haz_a, haz_b;

  function automatic int need(input logic [2:0] p, input logic [2:0] c, input logic data);
    if (p == C_FP && c == C_FP)         return LAT_FF;
    if (p == C_FP && c == C_SD && data) return LAT_FS;
    if (p == C_LD && c == C_FP)         return LAT_LF;
    if (p == C_LD && c == C_SD && data) return LAT_LS;
    if (p == C_INT && c == C_BR)        return LAT_IB;
    return 0;
  endfunction

  assign haz_a = in_a_en && (in_a != '0) &&
                 (int'(age[in_a]) < need(pcls[in_a], in_cls, 1'b0));
  assign haz_b = in_b_en && (in_b != '0) &&
                 (int'(age[in_b]) < need(pcls[in_b], in_cls, in_cls == C_SD));

  assign in_ready = rst_n && !(haz_a || haz_b);
  assign issue    = in_valid && in_ready;
  assign stall    = in_valid && rst_n && (haz_a || haz_b);

  for (genvar r = 0; r < NR; r++) begin : g_reg
    logic hit;
    assign hit = issue && in_dst_en && (in_dst == AW'(r)) && (r != 0);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age[r]  <= AMAX;
        pcls[r] <= C_NOP;
      end else if (hit) begin
        age[r]  <= '0;
        pcls[r] <= in_cls;
      end else if (age[r] != AMAX) begin
        age[r]  <= age[r] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              cycle_cnt <= '0;
    else if (issue || stall) cycle_cnt <= cycle_cnt + 1'b1;
  end
endmodule

// File: rtl/issue_interlock_chk.sv
module issue_interlock_chk #(
  parameter int AW     = 6,
  parameter int CW     = 16,
  parameter int LAT_FF = 3,
  parameter int LAT_FS = 2,
  parameter int LAT_LF = 1,
  parameter int LAT_LS = 0,
  parameter int LAT_IB = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_cls,
  input logic          in_dst_en,
  input logic [AW-1:0] in_dst,
  input logic          in_a_en,
  input logic [AW-1:0] in_a,
  input logic          in_b_en,
  input logic [AW-1:0] in_b,
  input logic          issue,
  input logic          stall,
  input logic [CW-1:0] cycle_cnt
);
  p_fp_fp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue && in_cls == 3'd1 && in_dst_en && in_dst != '0) && (LAT_FF > 0) &&
    in_valid && in_cls == 3'd1 && in_a_en && in_a == $past(in_dst) |-> stall);

  p_fp_sd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue && in_cls == 3'd1 && in_dst_en && in_dst != '0) && (LAT_FS > 0) &&
    in_valid && in_cls == 3'd2 && in_b_en && in_b == $past(in_dst) |-> stall);

  p_ld_fp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue && in_cls == 3'd0 && in_dst_en && in_dst != '0) && (LAT_LF > 0) &&
    in_valid && in_cls == 3'd1 && in_b_en && in_b == $past(in_dst) |-> stall);

  p_int_br_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue && in_cls == 3'd3 && in_dst_en && in_dst != '0) && (LAT_IB > 0) &&
    in_valid && in_cls == 3'd4 && in_a_en && in_a == $past(in_dst) |-> stall);

  p_zero_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (!in_a_en || in_a == '0) && (!in_b_en || in_b == '0) |-> in_ready && issue);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && stall));

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue || stall) |-> cycle_cnt == CW'($past(cycle_cnt) + 1'b1));

  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(issue || stall) |-> $stable(cycle_cnt));
endmodule

bind issue_interlock issue_interlock_chk #(
  .AW(AW), .CW(CW), .LAT_FF(LAT_FF), .LAT_FS(LAT_FS),
  .LAT_LF(LAT_LF), .LAT_LS(LAT_LS), .LAT_IB(LAT_IB)
) u_chk (.*);

// File: tb/sim_issue_interlock.sv
`timescale 1ns/1ps
module sim_issue_interlock;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready;
  logic [2:0] in_cls = '0;
  logic       in_dst_en = 1'b0, in_a_en = 1'b0, in_b_en = 1'b0;
  logic [5:0] in_dst = '0, in_a = '0, in_b = '0;
  logic       issue, stall;
  logic [15:0] cycle_cnt;

  always #2.5 clk = ~clk;

  issue_interlock u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst_en(in_dst_en), .in_dst(in_dst), .in_a_en(in_a_en), .in_a(in_a),
    .in_b_en(in_b_en), .in_b(in_b), .issue(issue), .stall(stall), .cycle_cnt(cycle_cnt));

  typedef struct { int c; int d; int a; int b; } ins_t;
  ins_t prog[$];
  int total = 0, bad = 0, cyc = 0, mcount = 0;
  int last_cyc [64];
  int last_cls [64];
  bit done = 0;

  function automatic ins_t mk(int c, int d, int a, int b);
    ins_t t; t.c = c; t.d = d; t.a = a; t.b = b; return t;
  endfunction
  function automatic int F(int n); return 32 + n; endfunction

  // gap table taken from R1..R5
  function automatic int gap(int p, int c, bit data);
    if (p == 1 && c == 1) return 3;
    if (p == 1 && c == 2 && data) return 2;
    if (p == 0 && c == 1) return 1;
    if (p == 0 && c == 2 && data) return 0;
    if (p == 3 && c == 4) return 1;
    return 0;
  endfunction

  function automatic bit src_ok(int r, int c, bit data);
    if (r <= 0) return 1;
    return (cyc - last_cyc[r] - 1) >= gap(last_cls[r], c, data);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      check(stall == 1'b0 && cycle_cnt == 16'(mcount), "R10 idle hold", int'(cycle_cnt), mcount);
      @(posedge clk);
      cyc++;
    end
  endtask

  task automatic run(string req, int exp_total);
    int start = mcount;
    while (prog.size() > 0) begin
      ins_t h = prog[0];
      bit er;
      @(negedge clk);
      in_valid  = 1'b1;
      in_cls    = 3'(h.c);
      in_dst_en = h.d >= 0; in_dst = 6'(h.d >= 0 ? h.d : 0);
      in_a_en   = h.a >= 0; in_a   = 6'(h.a >= 0 ? h.a : 0);
      in_b_en   = h.b >= 0; in_b   = 6'(h.b >= 0 ? h.b : 0);
      #1;
      er = src_ok(h.a, h.c, 1'b0) && src_ok(h.b, h.c, h.c == 2);
      check(in_ready == er && issue == er && stall == !er,
            {req, " R9 handshake"}, int'({in_ready, issue, stall}), int'({er, er, !er}));
      check(cycle_cnt == 16'(mcount), {req, " R10 count"}, int'(cycle_cnt), mcount);
      @(posedge clk);
      mcount++;
      if (er) begin
        if (h.d > 0) begin last_cyc[h.d] = cyc; last_cls[h.d] = h.c; end
        void'(prog.pop_front());
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(int'(cycle_cnt) - start == exp_total, {req, " total"}, int'(cycle_cnt) - start, exp_total);
    idle(6);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin last_cyc[i] = -1000; last_cls[i] = 5; end
    repeat (3) @(posedge clk);
    #1;
    check(cycle_cnt == 0 && issue == 0 && stall == 0, "R10 reset", int'(cycle_cnt), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); cyc++;

    for (int k = 0; k < 2; k++) begin
      prog.push_back(mk(0, F(0), 1, -1));
      prog.push_back(mk(1, F(4), F(0), F(2)));
      prog.push_back(mk(2, -1, 1, F(4)));
      prog.push_back(mk(3, 1, 1, -1));
      prog.push_back(mk(4, -1, 1, -1));
      prog.push_back(mk(5, -1, -1, -1));
    end
    run("R11 plain loop", 20);

    prog.push_back(mk(0, F(0), 1, -1));
    prog.push_back(mk(1, F(4), F(0), F(2)));
    prog.push_back(mk(3, 1, 1, -1));
    prog.push_back(mk(4, -1, 1, -1));
    prog.push_back(mk(2, -1, 1, F(4)));
    run("R11 slot filled", 7);

    for (int k = 0; k < 4; k++) prog.push_back(mk(0, F(6 + 4*k), 1, -1));
    for (int k = 0; k < 4; k++) prog.push_back(mk(1, F(8 + 4*k), F(6 + 4*k), F(2)));
    prog.push_back(mk(3, 1, 1, -1));
    for (int k = 0; k < 3; k++) prog.push_back(mk(2, -1, 1, F(8 + 4*k)));
    prog.push_back(mk(4, -1, 1, -1));
    prog.push_back(mk(2, -1, 1, F(20)));
    run("R11 unrolled", 14);

    prog.push_back(mk(1, F(4), F(0), F(2)));
    prog.push_back(mk(1, F(6), F(4), F(2)));
    run("R1 fp to fp", 5);

    prog.push_back(mk(1, F(4), F(0), F(2)));
    prog.push_back(mk(2, -1, 1, F(4)));
    run("R2 fp to store", 4);

    prog.push_back(mk(0, F(0), 1, -1));
    prog.push_back(mk(1, F(4), F(2), F(0)));
    run("R3 load to fp", 3);

    prog.push_back(mk(0, F(0), 1, -1));
    prog.push_back(mk(2, -1, 1, F(0)));
    run("R4 load to store", 2);

    prog.push_back(mk(3, 2, 2, -1));
    prog.push_back(mk(4, -1, 2, -1));
    run("R5 int to branch", 3);

    prog.push_back(mk(1, F(4), F(0), F(2)));
    prog.push_back(mk(0, F(20), 1, -1));
    prog.push_back(mk(1, F(6), F(4), F(2)));
    run("R6 filler", 5);

    prog.push_back(mk(1, F(4), F(0), F(2)));
    prog.push_back(mk(0, F(0), 1, -1));
    run("R7 anti", 2);

    prog.push_back(mk(1, F(4), F(0), F(2)));
    prog.push_back(mk(0, F(4), 1, -1));
    run("R7 output", 2);

    prog.push_back(mk(3, 2, 2, -1));
    prog.push_back(mk(2, -1, 2, F(0)));
    run("R7 unlisted", 2);

    prog.push_back(mk(3, 0, 2, -1));
    prog.push_back(mk(4, -1, 0, -1));
    run("R8 int zero", 2);

    prog.push_back(mk(1, F(0), F(2), F(2)));
    prog.push_back(mk(1, F(6), F(0), F(2)));
    run("R8 fp zero real", 5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule